// File: doc/BRIEF.md
# Two-wire serial clock generator

This block produces the serial clock timing for a two-wire bus master. A prescaler divides the system clock down to a reference tick of roughly 10 MHz. The prescale value is the system clock in MHz divided by ten, rounded to the nearest integer. Two 8-bit half counts, packed into one 16-bit divider word, then set how many reference ticks the clock spends high and how many it spends low. High and low can therefore be set independently rather than through one symmetric divide.

For a target bus rate in kHz, each half count is `(10000 / rate + 1) / 2` with integer division, and a symmetric clock places the same value in both bytes. Software asserts the fast-mode control when the target rate exceeds 100 kHz. The generator samples that control at each phase boundary and reports it to the transfer engine.

Nothing runs until the enable input is set. Clearing enable parks the clock high, and the divider setting stays on its input for the next enable. A new divider value is picked up only at a phase boundary, so software may write it at any time without producing a runt pulse. The transfer engine uses the phase level and the one-cycle edge strobes to place its data changes and its sampling points.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is asserted, `sclLevel` is 1 and `refTick`, `riseStb`, `fallStb` and `fastActive` are all 0.
- R2: While enabled, `refTick` is a one-cycle pulse repeating every `prescaleVal` system cycles. A prescale value of 0 behaves as 1, which puts a tick on every cycle.
- R3: While `enable` is low, the cycle after each clock edge shows `sclLevel` = 1 and shows `refTick`, `riseStb`, `fallStb` and `fastActive` all at 0.
- R4: After `enable` rises, the clock starts with a complete high phase. Counted from the first enabled edge, that phase lasts `divWord[15:8]` × prescale system cycles.
- R5: In steady running, a high phase lasts `divWord[15:8]` reference ticks and a low phase lasts `divWord[7:0]` reference ticks. `sclLevel` falls only together with `fallStb`.
- R6: A half count of 0 behaves as 1, so a phase set to 0 lasts exactly one reference tick.
- R7: `riseStb` and `fallStb` are one-cycle pulses. They appear in the first cycle of the new level, only in the cycle after a `refTick`, and never together.
- R8: Both half counts are captured when a phase begins. A change to `divWord` in the middle of a phase leaves the current phase unchanged and governs the phases that start after it.
- R9: `fastActive` takes the value of `fastMode` when the clock is enabled and at each phase boundary. It holds that value in between.
- R10: Clearing `enable` in the middle of a low phase drives `sclLevel` high without an edge strobe. The next enable begins a fresh, full high phase that uses the current divider word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| prescaleVal | input | 7 | System cycles per reference tick (0 behaves as 1) |
| divWord | input | 16 | Upper byte: high-phase ticks; lower byte: low-phase ticks |
| enable | input | 1 | Global run control |
| fastMode | input | 1 | Fast-rate request, sampled at phase boundaries |
| refTick | output | 1 | One-cycle reference tick strobe |
| sclLevel | output | 1 | Current serial clock phase level |
| riseStb | output | 1 | One-cycle strobe in the first cycle of a high phase |
| fallStb | output | 1 | One-cycle strobe in the first cycle of a low phase |
| fastActive | output | 1 | Fast-mode value latched for the current phase |

## Verification
The bench builds the block with its default widths: a 7-bit prescale and 8-bit half counts. It drives the inputs with small prescale and half-count values, so that every phase lasts only a few to a few dozen cycles. This brings within reach, in a short run, the zero-substitution paths for both the prescaler and the half counts, a divider rewrite in the middle of a phase, and a disable followed by a re-enable. A behavioural reference model compares every output on every cycle. Directed phase-length measurements pin down R4, R6, R8 and R10.

// File: rtl/scl_clock_pkg.sv
package scl_clock_pkg;
  // Strobes from the control part to the counting datapath.
  typedef struct packed {
    logic run;    // prescaler may advance
    logic load;   // capture both half counts and restart the phase count
    logic count;  // advance the phase count by one reference tick
  } dpCtlT;
endpackage

// File: rtl/scl_clock_dp.sv
module scl_clock_dp
  import scl_clock_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtlT               ctl,
  input  logic [PRE_W-1:0]    prescaleVal,
  input  logic [2*HALF_W-1:0] divWord,
  input  logic                levelSel,
  output logic                refTick,
  output logic                phaseEnd
);
  localparam int NUM_HALF = 2;

  logic [PRE_W-1:0]  effPre;
  logic [PRE_W-1:0]  preCnt;
  logic [HALF_W-1:0] phCnt;
  logic [HALF_W-1:0] curLim;
  logic [HALF_W-1:0] halfFix [NUM_HALF];
  logic [HALF_W-1:0] limReg  [NUM_HALF];

  // Zero prescale stands for one so the prescaler never stalls.
  assign effPre = (prescaleVal == '0) ? PRE_W'(1) : prescaleVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      refTick <= 1'b0;
    end else if (!ctl.run) begin
      preCnt  <= '0;
      refTick <= 1'b0;
    end else if (preCnt >= effPre - PRE_W'(1)) begin
      preCnt  <= '0;
      refTick <= 1'b1;
    end else begin
      preCnt  <= preCnt + PRE_W'(1);
      refTick <= 1'b0;
    end
  end

  // Index 1 is the high phase (upper byte), index 0 the low phase.
  for (genvar g = 0; g < NUM_HALF; g++) begin : gHalf
    assign halfFix[g] = (divWord[g*HALF_W +: HALF_W] == '0) ?
                        HALF_W'(1) : divWord[g*HALF_W +: HALF_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         limReg[g] <= HALF_W'(1);
      else if (ctl.load) limReg[g] <= halfFix[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phCnt <= '0;
    else if (ctl.load)  phCnt <= '0;
    else if (ctl.count) phCnt <= phCnt + HALF_W'(1);
  end

  assign curLim   = levelSel ? limReg[1] : limReg[0];
  assign phaseEnd = (phCnt >= curLim - HALF_W'(1));
endmodule

// File: rtl/scl_clock_ctl.sv
module scl_clock_ctl
  import scl_clock_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  enable,
  input  logic  fastMode,
  input  logic  refTick,
  input  logic  phaseEnd,
  output dpCtlT ctl,
  output logic  sclLevel,
  output logic  riseStb,
  output logic  fallStb,
  output logic  fastActive
);
  logic active;
  logic startUp;
  logic boundary;

  always_comb begin
    startUp   = enable && !active;
    boundary  = enable && active && refTick && phaseEnd;
    ctl.run   = enable;
    ctl.load  = startUp || boundary;
    ctl.count = enable && active && refTick && !phaseEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      sclLevel   <= 1'b1;
      riseStb    <= 1'b0;
      fallStb    <= 1'b0;
      fastActive <= 1'b0;
    end else if (!enable) begin
      active     <= 1'b0;
      sclLevel   <= 1'b1;
      riseStb    <= 1'b0;
      fallStb    <= 1'b0;
      fastActive <= 1'b0;
    end else begin
      active  <= 1'b1;
      riseStb <= boundary && !sclLevel;
      fallStb <= boundary && sclLevel;
      if (startUp)       sclLevel <= 1'b1;
      else if (boundary) sclLevel <= !sclLevel;
      if (ctl.load) fastActive <= fastMode;
    end
  end
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_clock_pkg::*;
#(
  parameter int PRE_W  = 7,
  parameter int HALF_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PRE_W-1:0]    prescaleVal,
  input  logic [2*HALF_W-1:0] divWord,
  input  logic                enable,
  input  logic                fastMode,
  output logic                refTick,
  output logic                sclLevel,
  output logic                riseStb,
  output logic                fallStb,
  output logic                fastActive
);
  dpCtlT dpCtl;
  logic  phaseEnd;

  scl_clock_ctl u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .fastMode(fastMode),
    .refTick(refTick), .phaseEnd(phaseEnd), .ctl(dpCtl),
    .sclLevel(sclLevel), .riseStb(riseStb), .fallStb(fallStb),
    .fastActive(fastActive)
  );

  scl_clock_dp #(.PRE_W(PRE_W), .HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .prescaleVal(prescaleVal),
    .divWord(divWord), .levelSel(sclLevel), .refTick(refTick),
    .phaseEnd(phaseEnd)
  );
endmodule

// File: rtl/scl_clock_chk.sv
module scl_clock_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic refTick,
  input logic sclLevel,
  input logic riseStb,
  input logic fallStb,
  input logic fastActive
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclLevel && !refTick && !riseStb && !fallStb && !fastActive)); // R3
  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    refTick |-> $past(enable)); // R2
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStb && fallStb)); // R7
  AST_RISE_TRUE: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> (sclLevel && !$past(sclLevel))); // R7
  AST_FALL_TRUE: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> (!sclLevel && $past(sclLevel))); // R7
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (riseStb || fallStb) |-> $past(refTick)); // R7
  AST_FELL_STROBED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclLevel) |-> fallStb); // R5
endmodule

bind scl_clock_gen scl_clock_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .refTick(refTick),
  .sclLevel(sclLevel), .riseStb(riseStb), .fallStb(fallStb),
  .fastActive(fastActive)
);

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  prescaleVal = 7'd1;
  logic [15:0] divWord = 16'h0303;
  logic        enable = 1'b0;
  logic        fastMode = 1'b0;
  logic        refTick, sclLevel, riseStb, fallStb, fastActive;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scl_clock_gen u0 (
    .clk(clk), .rstN(rstN), .prescaleVal(prescaleVal), .divWord(divWord),
    .enable(enable), .fastMode(fastMode), .refTick(refTick),
    .sclLevel(sclLevel), .riseStb(riseStb), .fallStb(fallStb),
    .fastActive(fastActive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: integers describing tick spacing and phase lengths.
  int  mPre = 0, mPh = 0, mHi = 1, mLo = 1;
  bit  mTick = 0, mActive = 0, mLvl = 1, mRise = 0, mFall = 0, mFast = 0;

  function automatic int fixHalf(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk) begin
    if (!rstN || !enable) begin
      mPre = 0; mTick = 0; mActive = 0; mLvl = 1; mPh = 0;
      mRise = 0; mFall = 0; mFast = 0;
    end else begin
      int ep;
      bit nTick;
      ep = (prescaleVal == 0) ? 1 : int'(prescaleVal);
      nTick = (mPre + 1 >= ep);
      mPre = nTick ? 0 : mPre + 1;
      mRise = 0; mFall = 0;
      if (!mActive) begin
        mActive = 1; mLvl = 1; mPh = 0; mFast = fastMode;
        mHi = fixHalf(int'(divWord[15:8])); mLo = fixHalf(int'(divWord[7:0]));
      end else if (mTick) begin
        if (mPh + 1 >= (mLvl ? mHi : mLo)) begin
          mLvl = !mLvl; mRise = mLvl; mFall = !mLvl; mPh = 0; mFast = fastMode;
          mHi = fixHalf(int'(divWord[15:8])); mLo = fixHalf(int'(divWord[7:0]));
        end else begin
          mPh++;
        end
      end
      mTick = nTick;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(refTick == mTick, "R2 refTick vs model", refTick, mTick);
      check(sclLevel == mLvl, "R5 sclLevel vs model", sclLevel, mLvl);
      check(riseStb == mRise, "R7 riseStb vs model", riseStb, mRise);
      check(fallStb == mFall, "R7 fallStb vs model", fallStb, mFall);
      check(fastActive == mFast, "R9 fastActive vs model", fastActive, mFast);
    end
  end

  task automatic waitStrobe(input bit rise);
    int n = 0;
    @(negedge clk);
    while (!(rise ? riseStb : fallStb) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(input bit lvl, input int exp, input string tag);
    int n = 0;
    while (sclLevel == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic countTicks(input int cycles, input int exp, input string tag);
    int n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (refTick) n++;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sclLevel == 1'b1, "R1 sclLevel in reset", sclLevel, 1);
    check({refTick, riseStb, fallStb, fastActive} == 4'b0, "R1 strobes in reset",
          {refTick, riseStb, fallStb, fastActive}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sclLevel == 1'b1 && !refTick, "R3 idle while disabled", {sclLevel, refTick}, 2);

    // R4/R5: prescale 2, high 3 ticks, low 5 ticks
    prescaleVal = 7'd2;
    divWord = {8'd3, 8'd5};
    enable = 1'b1;
    @(negedge clk);
    measure(1'b1, 6, "R4 first high phase length");
    check(fallStb == 1'b1, "R7 fallStb at fall", fallStb, 1);
    measure(1'b0, 10, "R5 low phase length");
    check(riseStb == 1'b1, "R7 riseStb at rise", riseStb, 1);
    measure(1'b1, 6, "R5 high phase length");
    check(fallStb == 1'b1, "R7 fallStb at second fall", fallStb, 1);
    @(negedge clk);
    check(fallStb == 1'b0, "R7 fallStb single cycle", fallStb, 0);

    // R2: tick spacing, including prescale 0
    countTicks(40, 20, "R2 ticks at prescale 2");
    prescaleVal = 7'd0;
    repeat (2) @(negedge clk);
    countTicks(20, 20, "R2 ticks at prescale 0");
    prescaleVal = 7'd5;
    repeat (10) @(negedge clk);
    countTicks(50, 10, "R2 ticks at prescale 5");

    // R6: zero half counts
    prescaleVal = 7'd3;
    divWord = 16'h0000;
    waitStrobe(1'b0);
    measure(1'b0, 3, "R6 zero low count");
    measure(1'b1, 3, "R6 zero high count");

    // R8/R9: mid-phase rewrite
    prescaleVal = 7'd1;
    divWord = {8'd4, 8'd4};
    fastMode = 1'b0;
    waitStrobe(1'b0);
    waitStrobe(1'b1);
    divWord = {8'd9, 8'd2};
    fastMode = 1'b1;
    @(negedge clk);
    check(fastActive == 1'b0, "R9 fastActive held mid-phase", fastActive, 0);
    measure(1'b1, 3, "R8 current high keeps old count");
    check(fastActive == 1'b1, "R9 fastActive taken at boundary", fastActive, 1);
    measure(1'b0, 2, "R8 next low uses new count");
    measure(1'b1, 9, "R8 next high uses new count");

    // R10: disable during low, re-enable
    waitStrobe(1'b0);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(sclLevel == 1'b1, "R10 level high after disable", sclLevel, 1);
    check({riseStb, fallStb, refTick, fastActive} == 4'b0, "R10 no strobes on disable",
          {riseStb, fallStb, refTick, fastActive}, 0);
    repeat (5) @(negedge clk);
    check(sclLevel == 1'b1 && !refTick, "R3 stays idle", {sclLevel, refTick}, 2);
    divWord = {8'd2, 8'd3};
    prescaleVal = 7'd2;
    enable = 1'b1;
    @(negedge clk);
    measure(1'b1, 4, "R10 fresh high after re-enable");
    measure(1'b0, 6, "R10 low after re-enable");

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule